// File: doc/BRIEF.md
# Programmable chip-select address decoder

This block watches each bus cycle and drives one active-low select line per channel. There are ten channels: one for upper memory, one for lower memory and eight general-purpose. Each channel is described by two registers. The start register holds a 10-bit start tag. The stop register holds a 10-bit stop tag plus four control bits: enable, ignore-stop, memory/I-O type and a ready-control flag.

For every bus cycle a 10-bit tag is taken from the address. A memory cycle uses address bits 19:10 and an I/O cycle uses address bits 15:6. A channel selects when all of these hold:
- the tag is at least the start tag;
- the tag is strictly below the stop tag, or ignore-stop is set, which stretches the window to the top of the space;
- the channel is enabled;
- the channel's type matches the cycle.

Software programs the channels through a simple write port. The port carries a channel index and a start/stop selector. A registered read-back port returns the stored words, and reserved bits read as zero.

The upper-memory channel leaves reset already enabled, with ignore-stop set, so a boot region decodes before any register is written. The select outputs are registered and stay high whenever no bus cycle is valid.

Top module: `csdec_top`

## Requirements
- R1: After reset, `cs_n` is all ones. Channel 0 reads back start 0x03FF and stop 0x0FFF (enable and ignore-stop set). Every other channel reads back start 0x0000 and stop 0x03FF.
- R2: For a memory cycle (`bus_io`=0), the tag is `bus_addr[19:10]`. A memory channel selects exactly when start <= tag < stop. A tag equal to the stop tag does not select.
- R3: For an I/O cycle (`bus_io`=1), the tag is `bus_addr[15:6]`, and address bits 19:16 and 5:0 do not affect the decode. The window rule is the same as in R2.
- R4: When ignore-stop (stop bit 11) is set, the stop tag is not used, and a channel selects for every tag >= start, up to and including 0x3FF.
- R5: When enable (stop bit 10) is clear, the channel's `cs_n` bit stays high for every address and cycle type.
- R6: Stop bit 12 sets the channel type, where 1 means I/O and 0 means memory. A channel never selects on a cycle of the other type.
- R7: When `bus_valid` is 0, every `cs_n` bit is high at the next edge, whatever the address.
- R8: `cs_n` is registered. It changes only at the clock edge that samples the bus inputs, and it is steady between edges.
- R9: When `reg_we` is 1 at an edge, `reg_wdata` is written to channel `reg_idx`: the start register when `reg_sel`=0, the stop register when `reg_sel`=1. `reg_rdata` shows, one edge later, the word addressed by `reg_idx`/`reg_sel`.
- R10: Reserved bits read back as zero: bits 15:10 of a start word and bits 15:14 of a stop word. The ready flag (stop bit 13) is stored and read back, and it does not change the decode.
- R11: A `reg_idx` of 10 or more writes nothing and reads back 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Channel index for write and read-back |
| reg_sel | input | 1 | 0 selects the start register, 1 selects the stop register |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read-back word |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_io | input | 1 | 1 marks an I/O cycle, 0 a memory cycle |
| bus_addr | input | 20 | Bus cycle address |
| cs_n | output | 10 | Active-low selects, one per channel |

## Verification
All 1024 tags are swept for both memory and I/O cycles, first with the reset configuration and then with a programmed set of channels. That set includes:
- a normal window;
- a start-equals-stop window, which must never select;
- a one-tag I/O window;
- an ignore-stop window at the top;
- a disabled full-range channel;
- a full-range channel whose stop is 0x3FF, which shows the strict stop comparison at the last tag.

The I/O sweep sets address bits 19:16 and 5:0 to values that track the tag, so a decoder that took the wrong slice selects the wrong channels. A final sweep after one channel is disabled separates enable gating from the window compare. Register reads after writes that carry reserved bits, and writes to an out-of-range index, check the masking and the index guard.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int TAG_W   = 10;
  localparam int WORD_W  = 16;
  localparam int STOP_W  = 14;
  localparam int EN_BIT  = 10;
  localparam int IST_BIT = 11;
  localparam int IO_BIT  = 12;
  localparam int RDY_BIT = 13;
  localparam int MEM_LO  = 10;
  localparam int IO_LO   = 6;
  localparam logic [TAG_W-1:0] TAG_TOP = '1;
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_pkg::*;
#(
  parameter int NCH      = 10,
  parameter int IDX_W    = 4,
  parameter int UPPER_CH = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        sel,
  input  logic [WORD_W-1:0]           wdata,
  output logic [WORD_W-1:0]           rdata,
  output logic [NCH-1:0][TAG_W-1:0]   start_o,
  output logic [NCH-1:0][TAG_W-1:0]   stop_o,
  output logic [NCH-1:0]              en_o,
  output logic [NCH-1:0]              ist_o,
  output logic [NCH-1:0]              io_o
);
  localparam int PAD_START = WORD_W - TAG_W;
  localparam int PAD_STOP  = WORD_W - STOP_W;

  logic [NCH-1:0][TAG_W-1:0]  start_q;
  logic [NCH-1:0][STOP_W-1:0] stop_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [TAG_W-1:0]  START_RST = (c == UPPER_CH) ? TAG_TOP : '0;
    localparam logic [STOP_W-1:0] STOP_RST  = (c == UPPER_CH) ?
      STOP_W'((1 << IST_BIT) | (1 << EN_BIT) | int'(TAG_TOP)) : STOP_W'(TAG_TOP);
    logic hit_idx;
    assign hit_idx = we && (idx == IDX_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        start_q[c] <= START_RST;
        stop_q[c]  <= STOP_RST;
      end else if (hit_idx) begin
        if (sel) stop_q[c]  <= wdata[STOP_W-1:0];
        else     start_q[c] <= wdata[TAG_W-1:0];
      end
    end

    assign start_o[c] = start_q[c];
    assign stop_o[c]  = stop_q[c][TAG_W-1:0];
    assign en_o[c]    = stop_q[c][EN_BIT];
    assign ist_o[c]   = stop_q[c][IST_BIT];
    assign io_o[c]    = stop_q[c][IO_BIT];
  end

  logic [WORD_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (int'(idx) < NCH) begin
      if (sel) rd_next = {{PAD_STOP{1'b0}}, stop_q[idx]};
      else     rd_next = {{PAD_START{1'b0}}, start_q[idx]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/cs_window.sv
module cs_window
  import cs_pkg::*;
(
  input  logic             cyc_io,
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] start_tag,
  input  logic [TAG_W-1:0] stop_tag,
  input  logic             en,
  input  logic             ist,
  input  logic             io_type,
  output logic             hit
);
  logic above_start, below_stop;
  assign above_start = (tag >= start_tag);
  assign below_stop  = ist || (tag < stop_tag);
  assign hit = en && (io_type == cyc_io) && above_start && below_stop;
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import cs_pkg::*;
#(
  parameter int NCH      = 10,
  parameter int IDX_W    = 4,
  parameter int ADDR_W   = 20,
  parameter int UPPER_CH = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              reg_sel,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_io,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NCH-1:0]    cs_n
);
  logic [NCH-1:0][TAG_W-1:0] ch_start, ch_stop;
  logic [NCH-1:0]            ch_en, ch_ist, ch_io, ch_hit;
  logic [TAG_W-1:0]          tag_mem, tag_io, tag;
  logic                      unused_low;

  cs_regfile #(.NCH(NCH), .IDX_W(IDX_W), .UPPER_CH(UPPER_CH)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .start_o(ch_start), .stop_o(ch_stop),
    .en_o(ch_en), .ist_o(ch_ist), .io_o(ch_io)
  );

  assign tag_mem    = bus_addr[MEM_LO +: TAG_W];
  assign tag_io     = bus_addr[IO_LO +: TAG_W];
  assign tag        = bus_io ? tag_io : tag_mem;
  assign unused_low = ^bus_addr[IO_LO-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_win
    cs_window u_win (
      .cyc_io(bus_io), .tag(tag),
      .start_tag(ch_start[c]), .stop_tag(ch_stop[c]),
      .en(ch_en[c]), .ist(ch_ist[c]), .io_type(ch_io[c]),
      .hit(ch_hit[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)            cs_n <= '1;
    else if (bus_valid) cs_n <= ~ch_hit;
    else                cs_n <= '1;
  end
endmodule

// File: rtl/cs_check.sv
module cs_check #(
  parameter int NCH = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_valid,
  input logic           bus_io,
  input logic           reg_sel,
  input logic [15:0]    reg_rdata,
  input logic [NCH-1:0] cs_n,
  input logic [NCH-1:0] en_vec,
  input logic [NCH-1:0] io_vec
);
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> &cs_n);

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> &cs_n);

  assert_start_resv_R10: assert property (@(posedge clk) disable iff (rst)
    !reg_sel |=> (reg_rdata[15:10] == 6'd0));

  assert_stop_resv_R10: assert property (@(posedge clk) disable iff (rst)
    reg_sel |=> (reg_rdata[15:14] == 2'd0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      !en_vec[c] |=> cs_n[c]);
    assert_type_match_R6: assert property (@(posedge clk) disable iff (rst)
      (bus_io != io_vec[c]) |=> cs_n[c]);
  end
endmodule

bind csdec_top cs_check #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_io(bus_io),
  .reg_sel(reg_sel), .reg_rdata(reg_rdata), .cs_n(cs_n),
  .en_vec(ch_en), .io_vec(ch_io)
);

// File: tb/csdec_top_test.sv
`timescale 1ns/1ps
module csdec_top_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_we = 0;
  logic [3:0]  reg_idx = 0;
  logic        reg_sel = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        bus_valid = 0;
  logic        bus_io = 0;
  logic [19:0] bus_addr = 0;
  logic [9:0]  cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [9:0]  sh_start [10];
  logic [13:0] sh_stop  [10];

  always #2 clk = ~clk;

  csdec_top uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_io(bus_io), .bus_addr(bus_addr), .cs_n(cs_n)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_cs(logic v, logic io, logic [19:0] a);
    logic [9:0] t;
    logic [9:0] r;
    t = io ? a[15:6] : a[19:10];
    r = '1;
    for (int c = 0; c < 10; c++) begin
      if (v && sh_stop[c][10] && (sh_stop[c][12] == io) && (t >= sh_start[c]) &&
          (sh_stop[c][11] || (t < sh_stop[c][9:0])))
        r[c] = 1'b0;
    end
    return r;
  endfunction

  task automatic wr(int idx, logic sel, logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_idx = 4'(idx); reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (idx < 10) begin
      if (sel) sh_stop[idx] = d[13:0];
      else     sh_start[idx] = d[9:0];
    end
  endtask

  task automatic rd(string req, int idx, logic sel);
    logic [15:0] e;
    @(negedge clk);
    reg_idx = 4'(idx); reg_sel = sel;
    @(posedge clk); #1;
    if (idx >= 10) e = 16'h0;
    else if (sel)  e = {2'b00, sh_stop[idx]};
    else           e = {6'b0, sh_start[idx]};
    check(req, reg_rdata, e);
  endtask

  task automatic apply(string req, logic v, logic io, logic [19:0] a);
    @(negedge clk);
    bus_valid = v; bus_io = io; bus_addr = a;
    @(posedge clk); #1;
    check(req, {6'b0, cs_n}, {6'b0, exp_cs(v, io, a)});
  endtask

  task automatic sweep(string req, logic io);
    for (int t = 0; t < 1024; t++) begin
      logic [9:0] tg;
      tg = 10'(t);
      if (io) apply(req, 1'b1, 1'b1, {tg[3:0], tg, tg[5:0]});
      else    apply(req, 1'b1, 1'b0, {tg, 10'(t * 37)});
    end
  endtask

  function automatic logic [15:0] stopw(logic [9:0] s, bit en, bit ist, bit io, bit rdy);
    return {2'b11, rdy, io, ist, en, s};
  endfunction

  initial begin
    for (int c = 0; c < 10; c++) begin
      sh_start[c] = (c == 0) ? 10'h3FF : 10'h000;
      sh_stop[c]  = (c == 0) ? 14'h0FFF : 14'h03FF;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check("R1", {6'b0, cs_n}, 16'h03FF);
    rd("R1", 0, 0); rd("R1", 0, 1); rd("R1", 5, 0); rd("R1", 9, 1);
    sweep("R4", 1'b0);
    sweep("R6", 1'b1);

    wr(1, 0, 16'hFC10); wr(1, 1, stopw(10'h020, 1, 0, 0, 0));
    wr(2, 0, 16'h0020); wr(2, 1, stopw(10'h020, 1, 0, 0, 0));
    wr(3, 0, 16'h0005); wr(3, 1, stopw(10'h006, 1, 0, 1, 0));
    wr(4, 0, 16'h03F0); wr(4, 1, stopw(10'h000, 1, 1, 1, 0));
    wr(5, 0, 16'h0000); wr(5, 1, stopw(10'h3FF, 0, 1, 0, 0));
    wr(6, 0, 16'h0000); wr(6, 1, stopw(10'h3FF, 1, 0, 0, 0));
    wr(7, 0, 16'h0100); wr(7, 1, stopw(10'h180, 1, 0, 0, 1));
    wr(8, 0, 16'h0000); wr(8, 1, stopw(10'h000, 1, 1, 0, 0));
    wr(9, 0, 16'h0000); wr(9, 1, stopw(10'h001, 1, 0, 1, 0));
    for (int c = 1; c < 10; c++) begin
      rd("R9", c, 0);
      rd("R10", c, 1);
    end
    rd("R11", 12, 0); rd("R11", 15, 1);
    wr(12, 1, 16'h0000); wr(10, 0, 16'h03FF);
    for (int c = 0; c < 10; c++) begin
      rd("R11", c, 0);
      rd("R11", c, 1);
    end

    sweep("R2", 1'b0);
    sweep("R3", 1'b1);

    apply("R7", 1'b0, 1'b0, 20'h04000);
    apply("R7", 1'b0, 1'b1, 20'h00140);
    apply("R8", 1'b1, 1'b0, 20'h04000);
    @(negedge clk);
    bus_valid = 1; bus_io = 1; bus_addr = 20'h00140;
    #1 check("R8", {6'b0, cs_n}, {6'b0, exp_cs(1'b1, 1'b0, 20'h04000)});
    @(posedge clk); #1;
    check("R8", {6'b0, cs_n}, {6'b0, exp_cs(1'b1, 1'b1, 20'h00140)});

    wr(8, 1, stopw(10'h000, 0, 1, 0, 0));
    sweep("R5", 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule